// File: doc/BRIEF.md
# Three-Input ADC Scan Sequencer

This block drives a sigma-delta converter over a serial bus and reads its differential inputs one after another, in a fixed order that repeats. Each input has its own gain code. A channel change goes through a fixed sequence of writes. First, the converter's filter is forced into reset with the new gain already applied. Then the new input is selected. Then the forced reset is released, again with the gain. This keeps a result from one input from being reported as another's, and it keeps the gain from falling back to its default.

After the release, the block waits for a fresh falling edge on the converter's data-ready line. It then sends a read command and shifts in the conversion word, and presents the word with a channel tag and a one-cycle strobe. If data ready does not arrive within a programmable number of clocks, the block flags an error and starts the same channel's sequence again. An enable input starts the scan. When enable is dropped, the channel in progress finishes and the scan stops.

Top module: `adc_scan_seq`

## Requirements
- R1: Results come from channels 0, 1, 2, 0, 1, ... in that order, starting from channel 0 after reset. `res_ch` carries the channel number, binary coded.
- R2: Each channel's sequence begins with two command bytes, each followed by a mode byte. A command byte has bit 7 = 0, bits 6:4 = register select (001 = mode, 011 = data), bit 3 = 1 for a read and 0 for a write, bit 2 = 0, and bits 1:0 = channel. The first command byte is a mode write carrying the currently selected channel. The second command byte is a mode write carrying the new channel, and that channel becomes the selected one.
- R3: A mode byte has bits 7:5 = gain code of the new channel (taken from `gain_cfg[3*ch +: 3]`), bits 4:1 = 0 and bit 0 = forced filter reset. The first mode byte of a sequence has bit 0 = 1, and the second has bit 0 = 0.
- R4: After the second mode byte, no transaction starts until `drdy_n` has gone from high to low.
- R5: After data ready, the block sends the command byte for a data read (select 011, bit 3 = 1, the channel). It then reads a DATA_W-bit word, MSB first, and that word appears on `res_data`.
- R6: When `spi_cs_n` is high, `spi_sclk` is high. The block changes `spi_mosi` on the falling edge and the rising edge is the sampling point. Write transactions are 8 clock pulses long, MSB first, and data reads are DATA_W pulses long.
- R7: Between two transactions, `spi_cs_n` stays high for at least CS_GAP clock cycles.
- R8: `res_valid` is high for exactly one cycle per result, with `res_ch` and `res_data` valid in that cycle.
- R9: If data ready does not fall within TIMEOUT clocks of the start of the wait, `err_timeout` pulses for one cycle. The block then restarts the same channel from the first command byte, which carries that channel as the selected one.
- R10: A sequence begins only while `en` is high. If `en` drops, the channel in progress completes with its result and no further transaction follows. When `en` rises again, the scan resumes with the next channel.
- R11: After reset, `spi_cs_n` = 1, `spi_sclk` = 1, `res_valid` = 0, `err_timeout` = 0, and the selected channel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Scan enable |
| gain_cfg | input | 3*NUM_CH | Gain code per channel, channel i in bits 3i+2:3i |
| drdy_n | input | 1 | Converter data ready, active low |
| spi_sclk | output | 1 | Serial clock, idle high |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_ch | output | 2 | Channel tag of the result |
| res_data | output | DATA_W | Conversion word |
| err_timeout | output | 1 | One-cycle data-ready timeout flag |

## Verification
The assertions assume that `gain_cfg` is steady while a sequence runs. They also assume that the converter changes `spi_miso` only after a falling serial clock edge, and that `drdy_n` stays high for some cycles after the forced reset is released. The bench meets these assumptions: its converter model sets the gains before enabling and drives `spi_miso` only on detected falling edges. It also raises `drdy_n` at the end of the releasing write and lowers it only after a delay of at least six cycles, which is much shorter than the timeout.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int CH_W   = 2;
    localparam int GAIN_W = 3;
    localparam int BYTE_W = 8;

    localparam logic [2:0] RS_MODE = 3'b001;
    localparam logic [2:0] RS_DATA = 3'b011;

    typedef enum logic [2:0] {
        STEP_SEL_MODE,
        STEP_FSYNC_SET,
        STEP_SEL_CH,
        STEP_FSYNC_CLR,
        STEP_RD_CMD,
        STEP_RD_DATA
    } step_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_XFER,
        SQ_WAIT_RDY
    } seq_state_e;

    typedef enum logic [2:0] {
        SP_IDLE,
        SP_LEAD,
        SP_LOW,
        SP_HIGH,
        SP_GAP
    } spi_state_e;

    typedef struct packed {
        logic              is_read;
        logic [BYTE_W-1:0] cmd;
    } xfer_req_t;

    function automatic logic [BYTE_W-1:0] comms_byte(logic [2:0] rs, logic rd,
                                                     logic [CH_W-1:0] ch);
        return {1'b0, rs, rd, 1'b0, ch};
    endfunction

    function automatic logic [BYTE_W-1:0] mode_byte(logic [GAIN_W-1:0] gain,
                                                    logic fsync);
        return {gain, 4'b0000, fsync};
    endfunction

endpackage

// File: rtl/adc_spi_xfer.sv
module adc_spi_xfer
    import adc_scan_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int HALF_DIV = 2,
    parameter int CS_GAP   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_req_t         req,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rx,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int HC_W  = $clog2(HALF_DIV + 1);
    localparam int GC_W  = $clog2(CS_GAP + 1);

    spi_state_e        state;
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  bits_left;
    logic [HC_W-1:0]   hcnt;
    logic [GC_W-1:0]   gcnt;
    logic              half_end;

    assign half_end = (hcnt == HC_W'(HALF_DIV - 1));
    assign ready    = (state == SP_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SP_IDLE;
            sh        <= '0;
            bits_left <= '0;
            hcnt      <= '0;
            gcnt      <= '0;
            rx        <= '0;
            sclk      <= 1'b1;
            cs_n      <= 1'b1;
            mosi      <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SP_IDLE: begin
                    if (start) begin
                        sh        <= req.is_read ? '0
                                   : {req.cmd, {(DATA_W-BYTE_W){1'b0}}};
                        bits_left <= req.is_read ? CNT_W'(DATA_W) : CNT_W'(BYTE_W);
                        rx        <= '0;
                        hcnt      <= '0;
                        cs_n      <= 1'b0;
                        state     <= SP_LEAD;
                    end
                end
                SP_LEAD: begin
                    if (half_end) begin
                        sclk  <= 1'b0;
                        mosi  <= sh[DATA_W-1];
                        sh    <= sh << 1;
                        hcnt  <= '0;
                        state <= SP_LOW;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                SP_LOW: begin
                    if (half_end) begin
                        sclk      <= 1'b1;
                        rx        <= {rx[DATA_W-2:0], miso};
                        bits_left <= bits_left - 1'b1;
                        hcnt      <= '0;
                        state     <= SP_HIGH;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                SP_HIGH: begin
                    if (half_end) begin
                        hcnt <= '0;
                        if (bits_left == '0) begin
                            cs_n  <= 1'b1;
                            mosi  <= 1'b0;
                            done  <= 1'b1;
                            gcnt  <= '0;
                            state <= SP_GAP;
                        end else begin
                            sclk  <= 1'b0;
                            mosi  <= sh[DATA_W-1];
                            sh    <= sh << 1;
                            state <= SP_LOW;
                        end
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                SP_GAP: begin
                    if (gcnt == GC_W'(CS_GAP - 1)) state <= SP_IDLE;
                    else                           gcnt  <= gcnt + 1'b1;
                end
                default: state <= SP_IDLE;
            endcase
        end
    end

    // R6: clock parks high whenever the select line is inactive
    p_sclk_idle_r6: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R7: select stays high past the cycle it rises
    p_cs_gap_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n);

    // R7: a new transaction is never accepted during the gap
    p_no_start_in_gap_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !(cs_n == 1'b0));

endmodule

// File: rtl/adc_rdy_watch.sv
module adc_rdy_watch #(
    parameter int TIMEOUT = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic drdy_n,
    output logic rdy_fall,
    output logic expire
);
    localparam int TC_W = $clog2(TIMEOUT + 1);

    logic            s1, s2, s3;
    logic [TC_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= drdy_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rdy_fall = s3 & ~s2;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign expire = run && !rdy_fall && (cnt == TC_W'(TIMEOUT - 1));

    // R9: the sequencer leaves the wait as soon as the timeout fires
    p_expire_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [NUM_CH*GAIN_W-1:0] gain_cfg,
    input  logic                     xfer_ready,
    input  logic                     xfer_done,
    input  logic [DATA_W-1:0]        xfer_rx,
    output logic                     start,
    output xfer_req_t                req,
    output logic                     run_wait,
    input  logic                     rdy_fall,
    input  logic                     expire,
    output logic                     res_valid,
    output logic [CH_W-1:0]          res_ch,
    output logic [DATA_W-1:0]        res_data
);
    seq_state_e        state;
    step_e             step;
    logic [CH_W-1:0]   ch;
    logic [CH_W-1:0]   sel;
    logic [CH_W-1:0]   ch_next;
    logic [GAIN_W-1:0] gain;

    assign gain     = gain_cfg[int'(ch)*GAIN_W +: GAIN_W];
    assign ch_next  = (int'(ch) == NUM_CH - 1) ? '0 : ch + 1'b1;
    assign start    = (state == SQ_ISSUE) && xfer_ready;
    assign run_wait = (state == SQ_WAIT_RDY);

    always_comb begin
        req = '{is_read: 1'b0, cmd: '0};
        unique case (step)
            STEP_SEL_MODE:  req.cmd = comms_byte(RS_MODE, 1'b0, sel);
            STEP_FSYNC_SET: req.cmd = mode_byte(gain, 1'b1);
            STEP_SEL_CH:    req.cmd = comms_byte(RS_MODE, 1'b0, ch);
            STEP_FSYNC_CLR: req.cmd = mode_byte(gain, 1'b0);
            STEP_RD_CMD:    req.cmd = comms_byte(RS_DATA, 1'b1, ch);
            STEP_RD_DATA:   req.is_read = 1'b1;
            default:        req.cmd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            step      <= STEP_SEL_MODE;
            ch        <= '0;
            sel       <= '0;
            res_valid <= 1'b0;
            res_ch    <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (en) begin
                        step  <= STEP_SEL_MODE;
                        state <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    if (start) state <= SQ_XFER;
                end
                SQ_XFER: begin
                    if (xfer_done) begin
                        unique case (step)
                            STEP_FSYNC_CLR: state <= SQ_WAIT_RDY;
                            STEP_RD_DATA: begin
                                res_valid <= 1'b1;
                                res_ch    <= ch;
                                res_data  <= xfer_rx;
                                ch        <= ch_next;
                                step      <= STEP_SEL_MODE;
                                state     <= en ? SQ_ISSUE : SQ_IDLE;
                            end
                            default: begin
                                if (step == STEP_SEL_CH) sel <= ch;
                                step  <= step_e'(step + 3'd1);
                                state <= SQ_ISSUE;
                            end
                        endcase
                    end
                end
                SQ_WAIT_RDY: begin
                    if (rdy_fall) begin
                        step  <= STEP_RD_CMD;
                        state <= SQ_ISSUE;
                    end else if (expire) begin
                        step  <= STEP_SEL_MODE;
                        state <= SQ_ISSUE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R8: one strobe per result
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R1: tags stay within the scanned set
    p_tag_range_r1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (int'(res_ch) < NUM_CH));

    // R5: a result only follows a finished serial transaction
    p_result_after_xfer_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(xfer_done));

    // R4: leaving the wait needs a ready edge or a timeout
    p_wait_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (run_wait && !rdy_fall && !expire) |=> run_wait);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int DATA_W   = 24,
    parameter int HALF_DIV = 2,
    parameter int CS_GAP   = 3,
    parameter int TIMEOUT  = 1000000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [NUM_CH*GAIN_W-1:0] gain_cfg,
    input  logic                     drdy_n,
    output logic                     spi_sclk,
    output logic                     spi_cs_n,
    output logic                     spi_mosi,
    input  logic                     spi_miso,
    output logic                     res_valid,
    output logic [CH_W-1:0]          res_ch,
    output logic [DATA_W-1:0]        res_data,
    output logic                     err_timeout
);
    logic              start, xfer_ready, xfer_done;
    logic [DATA_W-1:0] xfer_rx;
    xfer_req_t         req;
    logic              run_wait, rdy_fall, expire;

    assign err_timeout = expire;

    adc_scan_fsm #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_fsm (
        .clk, .rst, .en, .gain_cfg,
        .xfer_ready, .xfer_done, .xfer_rx,
        .start, .req, .run_wait, .rdy_fall, .expire,
        .res_valid, .res_ch, .res_data
    );

    adc_spi_xfer #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP)) u_spi (
        .clk, .rst, .start, .req,
        .ready(xfer_ready), .done(xfer_done), .rx(xfer_rx),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
    );

    adc_rdy_watch #(.TIMEOUT(TIMEOUT)) u_watch (
        .clk, .rst, .run(run_wait), .drdy_n, .rdy_fall, .expire
    );

endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
    localparam int NUM_CH  = 3;
    localparam int DATA_W  = 24;
    localparam int CS_GAP  = 3;
    localparam int TIMEOUT = 200;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en = 1'b0;
    logic [8:0]        gain_cfg = {3'd7, 3'd2, 3'd5};
    logic              drdy_n = 1'b1;
    logic              spi_sclk, spi_cs_n, spi_mosi;
    logic              spi_miso = 1'b0;
    logic              res_valid, err_timeout;
    logic [1:0]        res_ch;
    logic [DATA_W-1:0] res_data;

    adc_scan_seq #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .HALF_DIV(2),
                   .CS_GAP(CS_GAP), .TIMEOUT(TIMEOUT)) dut (
        .clk, .rst, .en, .gain_cfg, .drdy_n,
        .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso,
        .res_valid, .res_ch, .res_data, .err_timeout
    );

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0;
    bit finished = 0;

    // converter / reference model state
    int step = 0, ch_e = 0, sel_e = 0;
    bit waiting = 0, hold = 0, quiet = 0;
    int since = 0, delay = 0, nconv = 0;
    int nb = 0, nfall = 0, gap = 1000;
    logic [DATA_W-1:0] cap, word;
    logic [25:0] exp_q[$];
    bit prev_cs = 1, prev_sclk = 1, prev_valid = 0;
    int n_res = 0, n_err = 0;
    int last_ch = -1;

    function automatic logic [7:0] cbyte(logic [2:0] rs, logic rd, int c);
        return {1'b0, rs, rd, 1'b0, 2'(c)};
    endfunction
    function automatic logic [7:0] mbyte(int c, logic fs);
        return {gain_cfg[c*3 +: 3], 4'b0000, fs};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic end_xact();
        int want = (step == 5) ? DATA_W : 8;
        chk(nb == want, "R6 length", nb, want);
        case (step)
            0: chk(cap[7:0] == cbyte(3'b001, 1'b0, sel_e), "R2 first command (R11 sel)", cap[7:0], cbyte(3'b001, 1'b0, sel_e));
            1: chk(cap[7:0] == mbyte(ch_e, 1'b1), "R3 reset-set mode byte", cap[7:0], mbyte(ch_e, 1'b1));
            2: begin
                chk(cap[7:0] == cbyte(3'b001, 1'b0, ch_e), "R2 channel select", cap[7:0], cbyte(3'b001, 1'b0, ch_e));
                sel_e = ch_e;
            end
            3: begin
                chk(cap[7:0] == mbyte(ch_e, 1'b0), "R3 reset-clear mode byte", cap[7:0], mbyte(ch_e, 1'b0));
                waiting = 1; since = 0; drdy_n = 1'b1;
                delay = 6 + (nconv * 17) % 50;
            end
            4: chk(cap[7:0] == cbyte(3'b011, 1'b1, ch_e), "R5 read command", cap[7:0], cbyte(3'b011, 1'b1, ch_e));
            default: begin
                exp_q.push_back({2'(ch_e), word});
                nconv++;
                drdy_n = 1'b1;
                if (!en) quiet = 1;
                ch_e = (ch_e + 1) % NUM_CH;
            end
        endcase
        step = (step == 5) ? 0 : step + 1;
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(!(spi_cs_n && !spi_sclk), "R6 idle clock", {spi_cs_n, spi_sclk}, 2'b11);
            if (en) quiet = 0;
            if (prev_cs && !spi_cs_n) begin
                chk(gap >= CS_GAP, "R7 select gap", gap, CS_GAP);
                chk(!waiting, "R4 early transaction", 1, 0);
                chk(!quiet, "R10 activity while disabled", 1, 0);
                nb = 0; nfall = 0; cap = '0;
                if (step == 5) word = 24'h800001 ^ (24'(nconv) * 24'h1F3A57);
            end
            if (!spi_cs_n) begin
                if (prev_sclk && !spi_sclk) begin
                    if (step == 5 && nfall < DATA_W) spi_miso = word[DATA_W-1-nfall];
                    nfall++;
                end
                if (!prev_sclk && spi_sclk) begin
                    cap = {cap[DATA_W-2:0], spi_mosi};
                    nb++;
                end
            end
            if (!prev_cs && spi_cs_n) end_xact();
            gap = spi_cs_n ? gap + 1 : 0;
            if (waiting) begin
                since++;
                if (!hold && since == delay) begin
                    drdy_n = 1'b0; waiting = 0;
                end
            end
            if (err_timeout) begin
                n_err++;
                chk(waiting && since >= TIMEOUT && since <= TIMEOUT + 4, "R9 timeout timing", since, TIMEOUT);
                waiting = 0; hold = 0; step = 0;
            end
            if (res_valid) begin
                logic [25:0] e;
                chk(!prev_valid, "R8 strobe width", 2, 1);
                if (exp_q.size() == 0) chk(0, "R8 unexpected result", 1, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(res_ch == e[25:24], "R1 channel tag", res_ch, e[25:24]);
                    chk(res_data == e[23:0], "R5 data word", res_data, e[23:0]);
                end
                n_res++;
                last_ch = int'(res_ch);
            end
            prev_valid = res_valid;
            prev_cs = spi_cs_n;
            prev_sclk = spi_sclk;
        end
    end

    initial begin
        int tch;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R11 reset cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b1, "R11 reset sclk", spi_sclk, 1);
        chk(res_valid == 1'b0, "R11 reset valid", res_valid, 0);
        chk(err_timeout == 1'b0, "R11 reset error", err_timeout, 0);
        repeat (20) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R10 idle while en low", spi_cs_n, 1);
        @(posedge clk); #1 en = 1'b1;
        wait (n_res == 4);
        chk(last_ch == 0, "R1 wraps to channel 0", last_ch, 0);
        // R10: drop enable mid-sequence
        wait (waiting == 1);
        @(posedge clk); #1 en = 1'b0;
        wait (n_res == 5);
        repeat (300) @(negedge clk);
        chk(n_res == 5 && spi_cs_n, "R10 stopped after current channel", n_res, 5);
        @(posedge clk); #1 en = 1'b1;
        wait (n_res == 6);
        chk(last_ch == 2, "R10 resumes with next channel", last_ch, 2);
        // R9: withhold data ready once
        @(posedge clk); #1 hold = 1;
        tch = ch_e;
        wait (n_err == 1);
        wait (n_res == 7);
        chk(last_ch == tch, "R9 same channel after restart", last_ch, tch);
        wait (n_res == 9);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R8 every read reported", exp_q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule